// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address into a physical address by walking a hashed page table held in memory. The top bits of the address pick one of a set of segment words. Each segment word supplies a 24-bit virtual segment identifier, two protection-key bits, a no-execute bit and a direct-store bit. The identifier and the page index are hashed into the address of a primary group of page table entries. If the primary group yields no hit, a secondary group at the complemented hash is searched.

The walker is started with a one-cycle strobe. It then reads entry words over a simple read/write master port with a one-word response. On a hit it returns the physical address and the read/write permission. When the referenced or changed flag of the winning entry must be updated, it writes that entry's second word back. Every walk ends with a one-cycle done pulse and one of five result codes. A translation cache in front of the walker and the fault dispatch behind it are left to the surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: The segment word used for a walk is entry `eff_addr[31:28]` of `seg_file`, with entry i at bits [32i+31:32i]. Its bits [23:0] are the segment identifier (VSID), bit 30 is the supervisor key flag, bit 29 is the user key flag, bit 28 is the no-execute flag and bit 31 is the direct-store flag.
- R2: With the direct-store flag set, the walk ends with result 4 after no memory access, and done is high in the second cycle after the start edge.
- R3: A code fetch (`is_code`=1) whose segment has the no-execute flag set ends with result 3 after no memory access, in the second cycle after the start edge. Data accesses to the same segment are walked normally.
- R4: Let the page index be `eff_addr[27:12]` and hash = ((VSID ^ page index) & 0x7FFFF) << 6. The primary group address is {tbl_reg[31:16],16'h0} | (hash & ({tbl_reg[8:0],16'h0} | 0xFFC0)).
- R5: The secondary group uses the hash ~hash & 0x1FFFFC0 with the same mask and base. It is searched only when the primary group yields no hit, and its entries must carry bit 6 = 1, while primary entries must carry bit 6 = 0.
- R6: Entry i of a group has its first word at group + 8i and its second word at group + 8i + 4. Slots are scanned from 0 upward. An entry matches when first-word bit 31 is set, bit 6 equals the group's H value, and (word & 0x7FFFFFBF) == (VSID << 7) | (page index >> 10). The first matching entry of a group decides that group.
- R7: The key is 1 when (user flag and `priv_user`=1) or (supervisor flag and `priv_user`=0), else 0. PP is second-word bits [1:0]. With key 0, read is always allowed and write is allowed unless PP=3. With key 1, PP=0 allows nothing, PP=1 or 3 allows read only, and PP=2 allows read and write. A code fetch needs read.
- R8: On a hit, `phys_addr` = {second word[31:12], eff_addr[11:0]} and `perm_rd`/`perm_wr` give the decoded rights. The second word with bit 8 set, plus bit 7 on a write, is written to its own address only if this changes it.
- R9: Result codes: 0 hit, 1 no match in either group, 2 a matching entry refused access and the secondary group gave no hit. For every non-hit result, `phys_addr` and both permission outputs are 0.
- R10: `done` is high for exactly one cycle per walk, and the outputs hold their values until the next start. A hit on primary slot 0 with no write-back raises done in the sixth cycle after the start edge.
- R11: After reset, done, both memory requests, `result`, `phys_addr` and the permissions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| eff_addr | input | 32 | Effective address to translate |
| is_write | input | 1 | 1 for a store access |
| is_code | input | 1 | 1 for an instruction fetch |
| priv_user | input | 1 | 1 when the access runs at user privilege |
| tbl_reg | input | 32 | Table base [31:16] and hash mask [8:0] |
| seg_file | input | 512 | Sixteen 32-bit segment words |
| mem_rd_req | output | 1 | Read request for one word |
| mem_wr_req | output | 1 | Write request for one word |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read response strobe |
| done | output | 1 | One-cycle end-of-walk pulse |
| phys_addr | output | 32 | Translated address |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| result | output | 3 | 0 hit, 1 miss, 2 protection, 3 no-execute, 4 direct-store |

## Verification
Segment-only outcomes (direct-store and no-execute) are due two cycles after the start edge, and the fastest table hit is due six cycles after it. Every entry read costs two more cycles with the bench's one-cycle memory, and a write-back adds one. The bench counts falling edges from the start strobe and compares that count exactly for these fixed-latency cases. For longer walks it waits for done in a bounded loop, samples all outputs on the falling edge where done is high, and checks one edge later that done has dropped and the result has held. Memory reads and writes made during each walk are counted by the bench's memory model, so searches that were skipped and write-backs that were suppressed are visible at the ports.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

   typedef enum logic [2:0] {
      RES_HIT    = 3'd0,
      RES_MISS   = 3'd1,
      RES_PROT   = 3'd2,
      RES_NOEXEC = 3'd3,
      RES_DSTORE = 3'd4
   } hptw_result_e;

   typedef struct packed {
      logic        direct;
      logic        sup_key;
      logic        usr_key;
      logic        noexec;
      logic [3:0]  unused;
      logic [23:0] vsid;
   } seg_word_t;

   localparam int WORD_BITS  = 32;
   localparam int PTE_BYTES  = 8;
   localparam int WORD1_OFS  = 4;
   localparam int REF_BIT    = 8;
   localparam int CHG_BIT    = 7;

endpackage

// File: rtl/hptw_seg_sel.sv
module hptw_seg_sel
   import hptw_pkg::*;
#(
   parameter int SEG_COUNT = 16,
   parameter int SEL_W     = $clog2(SEG_COUNT)
) (
   input  logic [SEG_COUNT*WORD_BITS-1:0] seg_file,
   input  logic [SEL_W-1:0]               sel,
   input  logic                           priv_user,
   output seg_word_t                      seg,
   output logic                           key
);

   logic [WORD_BITS-1:0] seg_arr [SEG_COUNT];

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_unpack
      assign seg_arr[g] = seg_file[g*WORD_BITS +: WORD_BITS];
   end

   assign seg = seg_word_t'(seg_arr[sel]);
   assign key = (seg.usr_key & priv_user) | (seg.sup_key & ~priv_user);

endmodule

// File: rtl/hptw_hash.sv
module hptw_hash (
   input  logic [23:0] vsid,
   input  logic [15:0] page_idx,
   input  logic [31:0] tbl_reg,
   output logic [31:0] pri_grp,
   output logic [31:0] sec_grp,
   output logic [31:0] tag
);

   logic [31:0] hash_p;
   logic [31:0] hash_s;
   logic [31:0] mask;
   logic [31:0] base;

   always_comb begin
      hash_p  = {7'b0, vsid[18:0] ^ {3'b0, page_idx}, 6'b0};
      hash_s  = ~hash_p & 32'h01FF_FFC0;
      mask    = {7'b0, tbl_reg[8:0], 16'hFFC0};
      base    = {tbl_reg[31:16], 16'h0000};
      pri_grp = base | (hash_p & mask);
      sec_grp = base | (hash_s & mask);
      tag     = {1'b0, vsid, 1'b0, page_idx[15:10]};
   end

endmodule

// File: rtl/hptw_pte_eval.sv
module hptw_pte_eval
   import hptw_pkg::*;
(
   input  logic [31:0] word,
   input  logic        h_sel,
   input  logic [31:0] tag,
   input  logic        key,
   input  logic        is_write,
   output logic        match,
   output logic        can_rd,
   output logic        can_wr,
   output logic        grant,
   output logic [31:0] upd_word,
   output logic        needs_wb
);

   logic [1:0] pp;

   assign pp    = word[1:0];
   assign match = word[31] & (word[6] == h_sel) & ((word & 32'h7FFF_FFBF) == tag);

   always_comb begin
      if (!key) begin
         can_rd = 1'b1;
         can_wr = (pp != 2'b11);
      end else begin
         unique case (pp)
            2'b00:   begin can_rd = 1'b0; can_wr = 1'b0; end
            2'b10:   begin can_rd = 1'b1; can_wr = 1'b1; end
            default: begin can_rd = 1'b1; can_wr = 1'b0; end
         endcase
      end
      grant    = is_write ? can_wr : can_rd;
      upd_word = word;
      upd_word[REF_BIT] = 1'b1;
      if (is_write) upd_word[CHG_BIT] = 1'b1;
      needs_wb = (upd_word != word);
   end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hptw_pkg::*;
#(
   parameter int SEG_COUNT   = 16,
   parameter int GROUP_SLOTS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [31:0]                    eff_addr,
   input  logic                           is_write,
   input  logic                           is_code,
   input  logic                           priv_user,
   input  logic [31:0]                    tbl_reg,
   input  logic [SEG_COUNT*WORD_BITS-1:0] seg_file,
   output logic                           mem_rd_req,
   output logic                           mem_wr_req,
   output logic [31:0]                    mem_addr,
   output logic [31:0]                    mem_wdata,
   input  logic [31:0]                    mem_rdata,
   input  logic                           mem_rvalid,
   output logic                           done,
   output logic [31:0]                    phys_addr,
   output logic                           perm_rd,
   output logic                           perm_wr,
   output logic [2:0]                     result
);

   localparam int SEL_W  = $clog2(SEG_COUNT);
   localparam int SLOT_W = (GROUP_SLOTS > 1) ? $clog2(GROUP_SLOTS) : 1;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

   if (SEG_COUNT < 2 || SEG_COUNT > 16 || (SEG_COUNT & (SEG_COUNT - 1)) != 0) begin : g_bad_seg
      $error("SEG_COUNT must be a power of two from 2 to 16");
   end
   if (GROUP_SLOTS < 1 || GROUP_SLOTS > 8 || (GROUP_SLOTS & (GROUP_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("GROUP_SLOTS must be a power of two from 1 to 8");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_CLASS, S_RD0, S_W0, S_RD1, S_W1, S_WB
   } walk_state_e;

   walk_state_e       state;
   logic [31:0]       ea_q;
   logic              rw_q;
   logic              code_q;
   logic [31:0]       tbl_q;
   seg_word_t         seg_q;
   logic              key_q;
   logic              h_q;
   logic              prim_prot_q;
   logic [SLOT_W-1:0] slot_q;
   logic [31:0]       wb_q;
   logic              done_q;
   logic [31:0]       phys_q;
   logic              prd_q;
   logic              pwr_q;
   hptw_result_e      result_q;

   seg_word_t   seg_now;
   logic        key_now;
   logic [31:0] pri_grp;
   logic [31:0] sec_grp;
   logic [31:0] tag;
   logic [31:0] pte_addr;
   logic        match;
   logic        can_rd;
   logic        can_wr;
   logic        grant;
   logic [31:0] upd_word;
   logic        needs_wb;
   logic        refuse;
   logic        miss_end;

   hptw_seg_sel #(.SEG_COUNT(SEG_COUNT), .SEL_W(SEL_W)) u_seg (
      .seg_file  (seg_file),
      .sel       (eff_addr[31 -: SEL_W]),
      .priv_user (priv_user),
      .seg       (seg_now),
      .key       (key_now)
   );

   hptw_hash u_hash (
      .vsid     (seg_q.vsid),
      .page_idx (ea_q[27:12]),
      .tbl_reg  (tbl_q),
      .pri_grp  (pri_grp),
      .sec_grp  (sec_grp),
      .tag      (tag)
   );

   hptw_pte_eval u_eval (
      .word     (mem_rdata),
      .h_sel    (h_q),
      .tag      (tag),
      .key      (key_q),
      .is_write (rw_q),
      .match    (match),
      .can_rd   (can_rd),
      .can_wr   (can_wr),
      .grant    (grant),
      .upd_word (upd_word),
      .needs_wb (needs_wb)
   );

   always_comb begin
      pte_addr   = (h_q ? sec_grp : pri_grp) + (32'(slot_q) * PTE_BYTES);
      mem_rd_req = (state == S_RD0) || (state == S_RD1);
      mem_wr_req = (state == S_WB);
      mem_addr   = pte_addr + (((state == S_RD1) || (state == S_WB)) ? 32'(WORD1_OFS) : 32'd0);
      mem_wdata  = wb_q;
      refuse     = (state == S_W1) && mem_rvalid && !grant;
      miss_end   = (state == S_W0) && mem_rvalid && !match && (slot_q == LAST_SLOT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         ea_q        <= '0;
         rw_q        <= 1'b0;
         code_q      <= 1'b0;
         tbl_q       <= '0;
         seg_q       <= '0;
         key_q       <= 1'b0;
         h_q         <= 1'b0;
         prim_prot_q <= 1'b0;
         slot_q      <= '0;
         wb_q        <= '0;
         done_q      <= 1'b0;
         phys_q      <= '0;
         prd_q       <= 1'b0;
         pwr_q       <= 1'b0;
         result_q    <= RES_HIT;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  ea_q     <= eff_addr;
                  rw_q     <= is_write;
                  code_q   <= is_code;
                  tbl_q    <= tbl_reg;
                  seg_q    <= seg_now;
                  key_q    <= key_now;
                  phys_q   <= '0;
                  prd_q    <= 1'b0;
                  pwr_q    <= 1'b0;
                  result_q <= RES_MISS;
                  state    <= S_CLASS;
               end
            end
            S_CLASS: begin
               if (seg_q.direct) begin
                  result_q <= RES_DSTORE;
                  done_q   <= 1'b1;
                  state    <= S_IDLE;
               end else if (code_q && seg_q.noexec) begin
                  result_q <= RES_NOEXEC;
                  done_q   <= 1'b1;
                  state    <= S_IDLE;
               end else begin
                  h_q         <= 1'b0;
                  slot_q      <= '0;
                  prim_prot_q <= 1'b0;
                  state       <= S_RD0;
               end
            end
            S_RD0: state <= S_W0;
            S_W0: begin
               if (mem_rvalid) begin
                  if (match) begin
                     state <= S_RD1;
                  end else if (slot_q != LAST_SLOT) begin
                     slot_q <= slot_q + 1'b1;
                     state  <= S_RD0;
                  end
               end
            end
            S_RD1: state <= S_W1;
            S_W1: begin
               if (mem_rvalid && grant) begin
                  phys_q <= {mem_rdata[31:12], ea_q[11:0]};
                  prd_q  <= can_rd;
                  pwr_q  <= can_wr;
                  wb_q   <= upd_word;
                  if (needs_wb) begin
                     state <= S_WB;
                  end else begin
                     result_q <= RES_HIT;
                     done_q   <= 1'b1;
                     state    <= S_IDLE;
                  end
               end
            end
            S_WB: begin
               result_q <= RES_HIT;
               done_q   <= 1'b1;
               state    <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase

         if (refuse || miss_end) begin
            if (!h_q) begin
               h_q         <= 1'b1;
               slot_q      <= '0;
               prim_prot_q <= refuse;
               state       <= S_RD0;
            end else begin
               result_q <= (refuse || prim_prot_q) ? RES_PROT : RES_MISS;
               done_q   <= 1'b1;
               state    <= S_IDLE;
            end
         end
      end
   end

   assign done      = done_q;
   assign phys_addr = phys_q;
   assign perm_rd   = prd_q;
   assign perm_wr   = pwr_q;
   assign result    = result_q;

   // R10: one-cycle end pulse
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: outputs hold while idle without a new start
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && !start) |=> ($stable(phys_addr) && $stable(result) && $stable(perm_rd)));

   // R2: direct-store ends without a memory access
   a_r2_dstore: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CLASS && seg_q.direct) |=> (done && result == RES_DSTORE && !mem_rd_req));

   // R3: refused code fetch ends without a memory access
   a_r3_noexec: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CLASS && !seg_q.direct && code_q && seg_q.noexec)
         |=> (done && result == RES_NOEXEC && !mem_rd_req));

   // R8: every write-back carries the referenced flag
   a_r8_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wdata[REF_BIT]);

   // R8: a store's write-back carries the changed flag
   a_r8_chg_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && rw_q) |-> mem_wdata[CHG_BIT]);

   // R7: a hit grants the right the access needed
   a_r7_hit_perm: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_HIT) |-> (perm_rd && (perm_wr || !rw_q)));

   // R9: non-hit results carry no translation
   a_r9_nohit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result != RES_HIT) |-> (phys_addr == 32'd0 && !perm_rd && !perm_wr));

endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] TBL = 32'h0012_0001;
   localparam logic [31:0] EA  = 32'h5ABC_D123;
   localparam logic [23:0] VS  = 24'h012345;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [31:0]  eff_addr = '0;
   logic         is_write = 1'b0;
   logic         is_code = 1'b0;
   logic         priv_user = 1'b0;
   logic [31:0]  tbl_reg = TBL;
   logic [511:0] seg_file;
   logic         mem_rd_req, mem_wr_req;
   logic [31:0]  mem_addr, mem_wdata;
   logic [31:0]  mem_rdata = '0;
   logic         mem_rvalid = 1'b0;
   logic         done;
   logic [31:0]  phys_addr;
   logic         perm_rd, perm_wr;
   logic [2:0]   result;

   logic [31:0] segs [16];
   logic [31:0] mem [logic [31:0]];
   int n_rd = 0, n_wr = 0;
   logic [31:0] last_wa = '0, last_wd = '0;
   int n_cmp = 0, n_bad = 0;
   int rd0 = 0, wr0 = 0, lat = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb
      for (int i = 0; i < 16; i++) seg_file[i*32 +: 32] = segs[i];

   hpt_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .eff_addr(eff_addr),
      .is_write(is_write), .is_code(is_code), .priv_user(priv_user),
      .tbl_reg(tbl_reg), .seg_file(seg_file),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .done(done), .phys_addr(phys_addr), .perm_rd(perm_rd), .perm_wr(perm_wr),
      .result(result)
   );

   always @(posedge clk) begin
      mem_rvalid <= mem_rd_req;
      if (mem_rd_req) begin
         mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         n_rd = n_rd + 1;
      end
      if (mem_wr_req) begin
         mem[mem_addr] = mem_wdata;
         n_wr = n_wr + 1;
         last_wa = mem_addr;
         last_wd = mem_wdata;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [15:0] pidx, input bit sec);
      logic [31:0] h, m;
      h = ((32'(vsid) ^ 32'(pidx)) & 32'h7FFFF) << 6;
      if (sec) h = ~h & 32'h01FF_FFC0;
      m = (32'(TBL[8:0]) << 16) | 32'hFFC0;
      return {TBL[31:16], 16'h0} | (h & m);
   endfunction

   function automatic logic [31:0] w0f(input logic [23:0] vsid, input logic [15:0] pidx, input bit h);
      return 32'h8000_0000 | (32'(vsid) << 7) | (32'(h) << 6) | 32'(pidx[15:10]);
   endfunction

   function automatic logic [31:0] w1f(input logic [19:0] rpn, input bit r, input bit c, input logic [1:0] pp);
      return {rpn, 12'h0} | (32'(r) << 8) | (32'(c) << 7) | 32'(pp);
   endfunction

   task automatic put(input logic [31:0] g, input int slot, input logic [31:0] a, input logic [31:0] b);
      mem[g + 32'(slot*8)]     = a;
      mem[g + 32'(slot*8) + 4] = b;
   endtask

   task automatic prep(input logic [31:0] seg5);
      mem.delete();
      for (int i = 0; i < 16; i++) segs[i] = {8'h00, 24'h0A0000 + 24'(i)};
      segs[5] = seg5;
   endtask

   task automatic walk(input logic [31:0] ea, input bit wr, input bit code, input bit user);
      @(negedge clk);
      eff_addr = ea; is_write = wr; is_code = code; priv_user = user; start = 1'b1;
      rd0 = n_rd; wr0 = n_wr;
      @(negedge clk);
      start = 1'b0; lat = 1;
      while (!done && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      check("R10 walk finished", 32'(done), 32'd1);
   endtask

   task automatic after_pulse(input logic [2:0] exp_res);
      @(negedge clk);
      check("R10 done dropped", 32'(done), 32'd0);
      check("R10 result held", 32'(result), 32'(exp_res));
   endtask

   task automatic t_reset();
      check("R11 done", 32'(done), 32'd0);
      check("R11 rd_req", 32'(mem_rd_req), 32'd0);
      check("R11 wr_req", 32'(mem_wr_req), 32'd0);
      check("R11 result", 32'(result), 32'd0);
      check("R11 phys", phys_addr, 32'd0);
      check("R11 perms", {30'd0, perm_rd, perm_wr}, 32'd0);
   endtask

   task automatic t_hit_ref();
      logic [31:0] g;
      prep({8'h00, VS});
      g = grp(VS, EA[27:12], 0);
      put(g, 0, w0f(VS, EA[27:12], 0) & 32'h7FFF_FFFF, w1f(20'h11111, 0, 0, 2'd2));
      put(g, 1, w0f(VS, EA[27:12] ^ 16'h0400, 0), w1f(20'h22222, 0, 0, 2'd2));
      put(g, 3, w0f(VS, EA[27:12], 0), w1f(20'hCAFE1, 0, 0, 2'd2));
      walk(EA, 0, 0, 0);
      check("R8 R4 R6 result", 32'(result), 32'd0);
      check("R8 phys", phys_addr, 32'hCAFE_1123);
      check("R8 perms rw", {30'd0, perm_rd, perm_wr}, 32'd3);
      check("R6 reads", 32'(n_rd - rd0), 32'd5);
      check("R8 one write", 32'(n_wr - wr0), 32'd1);
      check("R8 write addr", last_wa, g + 32'd28);
      check("R8 ref data", last_wd, w1f(20'hCAFE1, 1, 0, 2'd2));
      after_pulse(3'd0);
   endtask

   task automatic t_no_wb();
      logic [31:0] g;
      prep({8'h00, VS});
      g = grp(VS, EA[27:12], 0);
      put(g, 0, w0f(VS, EA[27:12], 0), w1f(20'h0BEEF, 1, 0, 2'd2));
      walk(EA, 0, 0, 0);
      check("R10 latency slot0", 32'(lat), 32'd6);
      check("R8 no write", 32'(n_wr - wr0), 32'd0);
      check("R8 phys", phys_addr, 32'h0BEE_F123);
      after_pulse(3'd0);
   endtask

   task automatic t_write_chg();
      logic [31:0] g;
      prep({8'h00, VS});
      g = grp(VS, EA[27:12], 0);
      put(g, 2, w0f(VS, EA[27:12], 0), w1f(20'h3C3C3, 1, 0, 2'd2));
      walk(EA, 1, 0, 0);
      check("R8 store hit", 32'(result), 32'd0);
      check("R8 chg write", last_wd, w1f(20'h3C3C3, 1, 1, 2'd2));
      check("R8 chg addr", last_wa, g + 32'd20);
      check("R8 one write", 32'(n_wr - wr0), 32'd1);
   endtask

   task automatic t_secondary();
      logic [31:0] gp, gs;
      prep({8'h00, VS});
      gp = grp(VS, EA[27:12], 0);
      gs = grp(VS, EA[27:12], 1);
      put(gp, 4, w0f(VS, EA[27:12], 1), w1f(20'h77777, 1, 0, 2'd2));
      put(gs, 0, w0f(VS, EA[27:12], 0), w1f(20'hAAAAA, 1, 0, 2'd2));
      put(gs, 5, w0f(VS, EA[27:12], 1), w1f(20'h55555, 1, 0, 2'd2));
      walk(EA, 0, 0, 0);
      check("R5 secondary hit", 32'(result), 32'd0);
      check("R5 R6 H select", phys_addr, 32'h5555_5123);
      check("R5 reads", 32'(n_rd - rd0), 32'd15);
   endtask

   task automatic t_miss();
      prep({8'h00, VS});
      walk(EA, 0, 0, 0);
      check("R9 miss", 32'(result), 32'd1);
      check("R9 miss reads", 32'(n_rd - rd0), 32'd16);
      check("R9 miss phys", phys_addr, 32'd0);
      check("R9 miss perms", {30'd0, perm_rd, perm_wr}, 32'd0);
      after_pulse(3'd1);
   endtask

   task automatic t_key1_none();
      prep({8'h20, VS});
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h12345, 1, 0, 2'd0));
      walk(EA, 0, 0, 1);
      check("R7 R9 key1 pp0 prot", 32'(result), 32'd2);
      check("R9 prot reads", 32'(n_rd - rd0), 32'd10);
      check("R9 prot perms", {30'd0, perm_rd, perm_wr}, 32'd0);
      check("R9 prot no write", 32'(n_wr - wr0), 32'd0);
   endtask

   task automatic t_key1_pp1();
      prep({8'h40, VS});
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h0F0F0, 1, 0, 2'd1));
      walk(EA, 0, 0, 0);
      check("R7 key1 pp1 read", 32'(result), 32'd0);
      check("R7 key1 pp1 perms", {30'd0, perm_rd, perm_wr}, 32'd2);
      walk(EA, 1, 0, 0);
      check("R7 key1 pp1 write", 32'(result), 32'd2);
   endtask

   task automatic t_key0();
      prep({8'h20, VS});
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h0A0A0, 1, 1, 2'd3));
      walk(EA, 0, 0, 0);
      check("R7 key0 pp3 read", 32'(result), 32'd0);
      check("R7 key0 pp3 perms", {30'd0, perm_rd, perm_wr}, 32'd2);
      walk(EA, 1, 0, 0);
      check("R7 key0 pp3 write", 32'(result), 32'd2);
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h0A0A0, 1, 1, 2'd0));
      walk(EA, 1, 0, 0);
      check("R7 key0 pp0 write", 32'(result), 32'd0);
      check("R7 key0 pp0 perms", {30'd0, perm_rd, perm_wr}, 32'd3);
   endtask

   task automatic t_prot_then_sec();
      prep({8'h20, VS});
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h11111, 1, 0, 2'd0));
      put(grp(VS, EA[27:12], 1), 2, w0f(VS, EA[27:12], 1), w1f(20'h99999, 1, 0, 2'd2));
      walk(EA, 0, 0, 1);
      check("R9 R5 sec overrides prot", 32'(result), 32'd0);
      check("R9 sec phys", phys_addr, 32'h9999_9123);
   endtask

   task automatic t_dstore();
      prep({8'h80, VS});
      walk(EA, 0, 0, 0);
      check("R2 result", 32'(result), 32'd4);
      check("R2 latency", 32'(lat), 32'd2);
      check("R2 no reads", 32'(n_rd - rd0), 32'd0);
      after_pulse(3'd4);
   endtask

   task automatic t_noexec();
      prep({8'h10, VS});
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h44444, 1, 0, 2'd2));
      walk(EA, 0, 1, 0);
      check("R3 result", 32'(result), 32'd3);
      check("R3 latency", 32'(lat), 32'd2);
      check("R3 no reads", 32'(n_rd - rd0), 32'd0);
      walk(EA, 0, 0, 0);
      check("R3 data access walks", 32'(result), 32'd0);
      segs[5] = {8'h00, VS};
      walk(EA, 0, 1, 0);
      check("R3 fetch allowed", 32'(result), 32'd0);
      check("R3 fetch phys", phys_addr, 32'h4444_4123);
   endtask

   task automatic t_other_seg();
      logic [31:0] ea7;
      ea7 = {4'h7, EA[27:0]};
      prep({8'h00, VS});
      segs[7] = {8'h00, 24'h00F00F};
      put(grp(VS, EA[27:12], 0), 0, w0f(VS, EA[27:12], 0), w1f(20'h66666, 1, 0, 2'd2));
      put(grp(24'h00F00F, EA[27:12], 0), 1, w0f(24'h00F00F, EA[27:12], 0), w1f(20'hD00D0, 1, 0, 2'd2));
      walk(ea7, 0, 0, 0);
      check("R1 segment pick", phys_addr, 32'hD00D_0123);
      check("R1 R4 reads", 32'(n_rd - rd0), 32'd3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      prep({8'h00, VS});
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_hit_ref();
      t_no_wb();
      t_write_chg();
      t_secondary();
      t_miss();
      t_key1_none();
      t_key1_pp1();
      t_key0();
      t_prot_then_sec();
      t_dstore();
      t_noexec();
      t_other_seg();
      repeat (2) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule